// File: doc/BRIEF.md
# Device Interrupt Router

This block collects interrupt requests from a parameterised set of numbered devices and turns each accepted request into a single post event. The event is aimed at a target CPU and carries a vector. Each device owns two 64-bit registers. The routing register holds the target CPU number and the vector. The control register holds a mask bit and a pending bit.

When a device with a clear mask raises its request line, the router does three things:
- it emits one post event built from that device's routing register;
- it masks the device in hardware;
- it records the device as pending.

Software later reads the pending state, clears it with a dedicated clear bit, and unmasks the device to re-arm it.

A dispatch register on the same register port lets software post an inter-processor interrupt directly. Only dispatch writes of type 0 produce an event; other types are discarded.

At most one post event leaves the block per cycle. The fixed order is:
1. a dispatch held over from the previous cycle;
2. a device request;
3. a fresh dispatch write.

Accesses to offsets that map to no register complete harmlessly and raise an error pulse.

Top module: `dev_irq_router`

## Requirements
- R1: After reset every device reads back masked (control word 0x4) with pending clear, every routing register reads 0, and `post_valid`, `reg_rdata` and `reg_err` are 0.
- R2: The routing register of device d sits at byte offset d*8. A write stores bits 12:8 as CPU and bits 5:0 as vector. A read returns the CPU in bits 12:8 and the vector in bits 5:0, with all other bits 0. Read data appears in the cycle after `reg_rd` and is 0 in any cycle not following a read.
- R3: The control register of device d sits at byte offset NUM_DEV*8 + d*8. A read returns mask in bit 2 and pending in bit 0, all other bits 0. A write loads the mask from bit 2. A 1 in bit 1 clears pending, and a 0 in bit 1 leaves pending unchanged.
- R4: A request on a masked device is dropped: no post event, and the pending bit does not change.
- R5: A request on an unmasked device sets its mask and pending bits. In the next cycle it gives a one-cycle `post_valid` with `post_cpu` and `post_vec` taken from its routing register. `post_cpu` and `post_vec` are 0 whenever `post_valid` is 0.
- R6: When several unmasked devices request in the same cycle, only the lowest-numbered one is accepted. The others are untouched and are taken in later cycles if their lines stay high.
- R7: A write to the dispatch register at byte offset 2*NUM_DEV*8 decodes the type from bits 17:16, the CPU from bits 12:8 and the vector from bits 5:0. Type 0 posts that CPU and vector. Types 1 to 3 post nothing.
- R8: When a device is accepted in the same cycle as a type-0 dispatch write, the device posts first and the dispatch posts in the following cycle. In the cycle that a held dispatch posts, no device is accepted.
- R9: An access to any other offset, or a read of the dispatch register, returns read data 0, pulses `reg_err` in the next cycle, and changes no register. Mapped accesses leave `reg_err` at 0.
- R10: When a device is accepted in the same cycle as a software write to its control register, the hardware set wins: mask and pending both end at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access; bits 2:0 ignored |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| reg_err | output | 1 | Pulse: previous access hit no register |
| dev_irq | input | NUM_DEV | Per-device interrupt request lines |
| post_valid | output | 1 | One-cycle post event strobe |
| post_cpu | output | 5 | Target CPU of the post event |
| post_vec | output | 6 | Vector of the post event |

## Verification
The bench builds the router with NUM_DEV = 8 and ADDR_W = 8.

With eight devices, the bench can write every routing and control register and read each one back, and it can drive all request lines at once to walk the lowest-index ordering end to end. The 8-bit offset space puts the dispatch register at 0x80 and leaves 0x88 to 0xF8 unmapped, so both error paths are reachable with ordinary offsets.

A random phase mixes request lines, writes of all four dispatch types and stray offsets against a behavioural model, so that held dispatches collide with new requests and with further dispatches.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int CPU_W = 5;
  localparam int VEC_W = 6;

  typedef struct packed {
    logic [CPU_W-1:0] cpu;
    logic [VEC_W-1:0] vec;
  } post_t;

  // routing readback: cpu in 12:8, vector in 5:0
  function automatic logic [63:0] route_word(post_t r);
    return {51'd0, r.cpu, 2'b00, r.vec};
  endfunction

  // control readback: mask in bit 2, pending in bit 0
  function automatic logic [63:0] ctl_word(logic mask, logic pend);
    return {61'd0, mask, 1'b0, pend};
  endfunction

  function automatic post_t field_post(logic [63:0] w);
    post_t p;
    p.cpu = w[12:8];
    p.vec = w[5:0];
    return p;
  endfunction

  function automatic logic [1:0] field_type(logic [63:0] w);
    return w[17:16];
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DEV-1:0]  route_we,
  input  logic [NUM_DEV-1:0]  ctl_we,
  input  post_t               wr_route,
  input  logic                wr_mask,
  input  logic                wr_clr,
  input  logic [NUM_DEV-1:0]  take,
  output logic [NUM_DEV-1:0]  mask,
  output logic [NUM_DEV-1:0]  pend,
  output post_t [NUM_DEV-1:0] route
);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route[i] <= '0;
      end else if (route_we[i]) begin
        route[i] <= wr_route;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[i] <= 1'b1;
        pend[i] <= 1'b0;
      end else if (take[i]) begin
        mask[i] <= 1'b1;
        pend[i] <= 1'b1;
      end else if (ctl_we[i]) begin
        mask[i] <= wr_mask;
        if (wr_clr) pend[i] <= 1'b0;
      end
    end

    // R4
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take[i] |=> !$rose(pend[i]));

    // R10
    take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |=> (mask[i] && pend[i]));
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_DEV = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [NUM_DEV-1:0] req,
  output logic [NUM_DEV-1:0] take,
  output logic               any
);

  logic [NUM_DEV-1:0] lowest;

  // isolate the lowest set request bit
  assign lowest = req & (~req + NUM_DEV'(1));
  assign take   = en ? lowest : '0;
  assign any    = |take;

  // R6
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  // R6
  take_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~req) == '0);

endmodule

// File: rtl/irq_post_arb.sv
module irq_post_arb
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_take,
  input  post_t            dev_post,
  input  logic             disp_fire,
  input  post_t            disp_post,
  output logic             hold_full,
  output logic             post_valid,
  output logic [CPU_W-1:0] post_cpu,
  output logic [VEC_W-1:0] post_vec
);

  post_t hold_q;
  post_t sel;
  logic  sel_valid;
  logic  hold_next;

  always_comb begin
    sel       = '0;
    sel_valid = 1'b1;
    if (hold_full)      sel = hold_q;
    else if (dev_take)  sel = dev_post;
    else if (disp_fire) sel = disp_post;
    else                sel_valid = 1'b0;
  end

  assign hold_next = disp_fire && (hold_full || dev_take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full  <= 1'b0;
      hold_q     <= '0;
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      hold_full  <= hold_next;
      if (hold_next) hold_q <= disp_post;
      post_valid <= sel_valid;
      post_cpu   <= sel.cpu;
      post_vec   <= sel.vec;
    end
  end

  // R8
  hold_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |=> post_valid);

  // R8
  hold_blocks_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> !dev_take);

  // R5
  idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !post_valid |-> (post_cpu == '0 && post_vec == '0));

endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               reg_err,
  input  logic [NUM_DEV-1:0] dev_irq,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);

  localparam int IDX_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int CTL_WORD  = NUM_DEV;
  localparam int DISP_WORD = 2 * NUM_DEV;

  // register decode
  logic [31:0]        word32;
  logic               hit_route, hit_ctl, hit_disp;
  logic [IDX_W-1:0]   route_idx, ctl_idx;
  logic [NUM_DEV-1:0] route_we, ctl_we;

  assign word32    = 32'(reg_addr[ADDR_W-1:3]);
  assign hit_route = word32 < 32'(CTL_WORD);
  assign hit_ctl   = (word32 >= 32'(CTL_WORD)) && (word32 < 32'(DISP_WORD));
  assign hit_disp  = word32 == 32'(DISP_WORD);
  assign route_idx = IDX_W'(word32);
  assign ctl_idx   = IDX_W'(word32 - 32'(CTL_WORD));

  always_comb begin
    route_we = '0;
    ctl_we   = '0;
    if (reg_wr && hit_route) route_we[route_idx] = 1'b1;
    if (reg_wr && hit_ctl)   ctl_we[ctl_idx]     = 1'b1;
  end

  // named internal events
  logic [NUM_DEV-1:0] mask, pend, take;
  post_t [NUM_DEV-1:0] route;
  logic  dev_take, hold_full, disp_fire;
  post_t dev_post;

  assign disp_fire = reg_wr && hit_disp && (field_type(reg_wdata) == 2'd0);

  irq_src_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .route_we (route_we),
    .ctl_we   (ctl_we),
    .wr_route (field_post(reg_wdata)),
    .wr_mask  (reg_wdata[2]),
    .wr_clr   (reg_wdata[1]),
    .take     (take),
    .mask     (mask),
    .pend     (pend),
    .route    (route)
  );

  irq_pick #(.NUM_DEV(NUM_DEV)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (!hold_full),
    .req   (dev_irq & ~mask),
    .take  (take),
    .any   (dev_take)
  );

  always_comb begin
    dev_post = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (take[i]) dev_post = route[i];
    end
  end

  irq_post_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_take   (dev_take),
    .dev_post   (dev_post),
    .disp_fire  (disp_fire),
    .disp_post  (field_post(reg_wdata)),
    .hold_full  (hold_full),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec)
  );

  // read path
  logic [63:0] rd_next;
  logic        err_next;

  always_comb begin
    rd_next = '0;
    if (reg_rd && hit_route)    rd_next = route_word(route[route_idx]);
    else if (reg_rd && hit_ctl) rd_next = ctl_word(mask[ctl_idx], pend[ctl_idx]);
  end

  assign err_next = (reg_rd && !(hit_route || hit_ctl)) ||
                    (reg_wr && !(hit_route || hit_ctl || hit_disp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      reg_err   <= err_next;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[63:18], reg_wdata[15:13], reg_wdata[7:6], reg_addr[2:0]};

  // R5
  take_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_take |=> post_valid);

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> reg_rdata == '0);

  // R2
  no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == '0);

endmodule

// File: tb/dev_irq_router_bench.sv
`timescale 1ns/1ps
module dev_irq_router_bench;

  localparam int N  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          reg_err;
  logic [N-1:0]  dev_irq = '0;
  logic          post_valid;
  logic [4:0]    post_cpu;
  logic [5:0]    post_vec;

  always #10 clk = ~clk;

  dev_irq_router #(.NUM_DEV(N), .ADDR_W(AW)) u_dev_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .dev_irq(dev_irq), .post_valid(post_valid),
    .post_cpu(post_cpu), .post_vec(post_vec)
  );

  // behavioural reference model
  int    m_cpu [N];
  int    m_vec [N];
  bit    m_mask[N];
  bit    m_pend[N];
  int    held_q[$];
  bit    e_valid, e_err;
  int    e_cpu, e_vec;
  longint unsigned e_rdata;
  int    w, acc, hv;
  bit    posted, hr, hc, hd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_cpu[i] = 0; m_vec[i] = 0; m_mask[i] = 1; m_pend[i] = 0;
      end
      held_q.delete();
      e_valid = 0; e_err = 0; e_cpu = 0; e_vec = 0; e_rdata = 0;
    end else begin
      w  = int'(reg_addr) / 8;
      hr = w < N;
      hc = (w >= N) && (w < 2 * N);
      hd = w == 2 * N;
      e_rdata = 0;
      if (reg_rd && hr) e_rdata = longint'(m_cpu[w]) * 256 + longint'(m_vec[w]);
      else if (reg_rd && hc) e_rdata = (m_mask[w-N] ? 4 : 0) + (m_pend[w-N] ? 1 : 0);
      e_err = (reg_rd && !(hr || hc)) || (reg_wr && !(hr || hc || hd));
      posted = 0; acc = -1;
      e_valid = 0; e_cpu = 0; e_vec = 0;
      if (held_q.size() > 0) begin
        hv = held_q.pop_front();
        e_valid = 1; e_cpu = hv / 256; e_vec = hv % 256; posted = 1;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (dev_irq[i] && !m_mask[i]) begin acc = i; break; end
        end
        if (acc >= 0) begin
          e_valid = 1; e_cpu = m_cpu[acc]; e_vec = m_vec[acc]; posted = 1;
        end
      end
      if (reg_wr && hd && reg_wdata[17:16] == 2'd0) begin
        hv = int'(reg_wdata[12:8]) * 256 + int'(reg_wdata[5:0]);
        if (posted) held_q.push_back(hv);
        else begin e_valid = 1; e_cpu = hv / 256; e_vec = hv % 256; end
      end
      if (reg_wr && hr) begin
        m_cpu[w] = int'(reg_wdata[12:8]); m_vec[w] = int'(reg_wdata[5:0]);
      end
      if (reg_wr && hc) begin
        m_mask[w-N] = reg_wdata[2];
        if (reg_wdata[1]) m_pend[w-N] = 0;
      end
      if (acc >= 0) begin m_mask[acc] = 1; m_pend[acc] = 1; end
    end
  end

  int    n_chk = 0, n_bad = 0;
  string cur_tag = "R1";
  bit    comparing = 0;
  bit    done = 0;

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      chk(cur_tag, "post_valid", longint'(post_valid), longint'(e_valid));
      chk(cur_tag, "post_cpu", longint'(post_cpu), longint'(e_cpu));
      chk(cur_tag, "post_vec", longint'(post_vec), longint'(e_vec));
      chk(cur_tag, "reg_rdata", reg_rdata, e_rdata);
      chk(cur_tag, "reg_err", longint'(reg_err), longint'(e_err));
    end
  end

  task automatic drive(bit wr, bit rd, int addr, longint unsigned data, logic [N-1:0] irq);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = AW'(addr); reg_wdata = data; dev_irq = irq;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, dev_irq);
  endtask

  task automatic rd(int addr);
    drive(0, 1, addr, 0, dev_irq);
  endtask

  task automatic wr(int addr, longint unsigned data);
    drive(1, 0, addr, data, dev_irq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    comparing = 1;
    // R1: reset state of every register
    cur_tag = "R1";
    for (int d = 0; d < 2 * N; d++) rd(d * 8);
    idle(1);
    // R2: routing write/readback, upper garbage discarded
    cur_tag = "R2";
    for (int d = 0; d < N; d++) wr(d * 8, 64'hFFFF_FFFF_FFFF_E0C0 | longint'(d * 9));
    wr(3 * 8, 64'h1F3F);
    for (int d = 0; d < N; d++) rd(d * 8 + (d % 8));
    idle(1);
    // R3: control write/readback, clear bit
    cur_tag = "R3";
    wr(N * 8 + 8, 64'h0);
    rd(N * 8 + 8);
    wr(N * 8 + 8, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(N * 8 + 8);
    idle(1);
    // R4: masked device request dropped
    cur_tag = "R4";
    drive(0, 0, 0, 0, 8'h10);
    idle(3);
    rd(N * 8 + 4 * 8);
    drive(0, 0, 0, 0, 8'h00);
    idle(1);
    // R5: unmasked request posts and self-masks
    cur_tag = "R5";
    wr(N * 8 + 3 * 8, 64'h0);
    drive(0, 0, 0, 0, 8'h08);
    drive(0, 0, 0, 0, 8'h00);
    idle(2);
    rd(N * 8 + 3 * 8);
    cur_tag = "R3";
    wr(N * 8 + 3 * 8, 64'h0);
    rd(N * 8 + 3 * 8);
    wr(N * 8 + 3 * 8, 64'h6);
    rd(N * 8 + 3 * 8);
    idle(1);
    // R6: all lines at once, lowest index first
    cur_tag = "R6";
    for (int d = 0; d < N; d++) wr(N * 8 + d * 8, 64'h2);
    drive(0, 0, 0, 0, '1);
    idle(N + 2);
    drive(0, 0, 0, 0, '0);
    for (int d = 0; d < N; d++) rd(N * 8 + d * 8);
    idle(1);
    // R7: dispatch of each type
    cur_tag = "R7";
    for (int t = 0; t < 4; t++) begin
      wr(2 * N * 8, (longint'(t) << 16) | 64'h1527 | (64'hF << 20));
      idle(2);
    end
    // R8: collision of request and dispatch
    cur_tag = "R8";
    wr(N * 8 + 5 * 8, 64'h2);
    wr(N * 8 + 6 * 8, 64'h2);
    drive(1, 0, 2 * N * 8, 64'h0A15, 8'h20);
    drive(1, 0, 2 * N * 8, 64'h0B16, 8'h60);
    drive(0, 0, 0, 0, 8'h40);
    idle(3);
    drive(0, 0, 0, 0, 8'h00);
    idle(1);
    // R9: unmapped offsets and dispatch read
    cur_tag = "R9";
    wr(2 * N * 8 + 8, 64'h0);
    rd(2 * N * 8 + 8);
    rd(2 * N * 8);
    wr(8'hF8, 64'h0);
    rd(8'hF8);
    rd(N * 8);
    rd(0);
    idle(1);
    // R10: control write loses to a same-cycle acceptance
    cur_tag = "R10";
    wr(N * 8 + 2 * 8, 64'h2);
    drive(1, 0, N * 8 + 2 * 8, 64'h2, 8'h04);
    drive(0, 1, N * 8 + 2 * 8, 0, 8'h00);
    idle(2);
    // R8: random mix against the model
    cur_tag = "R8";
    for (int k = 0; k < 400; k++) begin
      int unsigned r;
      r = $urandom;
      drive(r[0] && !r[1], r[1] && !r[0], int'(r[10:3]) & ((r[2]) ? 8'h87 : 8'hFF),
            {$urandom, $urandom}, N'($urandom));
    end
    drive(0, 0, 0, 0, '0);
    idle(4);
    comparing = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule